// File: doc/BRIEF.md
# Multi-Mode Capture Timer

This block is a 16-bit timer/counter pair that a 2-bit mode field splits into two 8-bit halves or joins into one 16-bit unit. The count source is either a shared 8-bit prescaler, which divides a system tick, or rising edges of an external event line after a synchronizer. Each half has its own match register. When a counter reaches its match value, it wraps to zero on its next count step and sends a single-cycle flag to a separate interrupt line for that half. Two capture strobes copy the live count into capture registers. In the 16-bit modes either strobe stores the full 16-bit value.

Software sets the block up through an 8-bit register port and reads back the counts and captures through the same port. The four modes are:

- Mode 0: two prescaled 8-bit timers.
- Mode 1: a prescaled 8-bit low timer plus an 8-bit event counter in the high half.
- Mode 2: one prescaled 16-bit timer.
- Mode 3: one 16-bit event counter.

Any write to the mode register restarts both counters and the prescaler.

Top module: `cap_timer`

## Requirements
- R1: With prescale register (address 1) holding N, the prescaler gives one count step per N+1 cycles that have `tick` high. A write to the mode register returns its phase to zero.
- R2: Mode 0 (mode bits 00) runs two 8-bit timers, low and high. Both step on the prescaler output. The low half compares against match address 2 and the high half against match address 3. A half that receives no step keeps its value.
- R3: Mode 1 (01) steps the low half from the prescaler. The high half counts rising edges of `evt_in` after a two-flop synchronizer: a level first driven before clock edge k is counted at edge k+2. Each rising edge is counted once.
- R4: Mode 2 (10) forms one 16-bit timer {high, low} that steps on the prescaler and matches against {address 3, address 2}. Only `irq_hi` can fire in this mode.
- R5: Mode 3 (11) forms one 16-bit counter of synchronized `evt_in` rising edges, matched against {address 3, address 2}.
- R6: On a count step, a counter (8-bit half or the 16-bit unit) equal to its match value becomes 0 and raises its flag for the cycle after that edge. Otherwise the step adds one. In 8-bit modes the low half drives `irq_lo` and the high half drives `irq_hi`.
- R7: In modes 0 and 1, `cap_lo_stb` copies the low count into capture-low (address 4) at the same edge, and `cap_hi_stb` copies the high count into capture-high (address 5). The value copied is the count held before that edge.
- R8: In modes 2 and 3, either strobe copies the full 16-bit count held before that edge into {address 5, address 4}.
- R9: A write to address 0 sets the mode from `wr_data[1:0]`, clears both counters, the prescaler phase and both flags, and suppresses counting at that edge.
- R10: The register port decodes these addresses:
  - 0: mode
  - 1: prescale
  - 2: match low
  - 3: match high
  - 4: capture low
  - 5: capture high
  - 6: count low
  - 7: count high

  Addresses 0 to 3 are writable. `rd_data` shows the addressed register combinationally.
- R11: After reset every register reads 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | System tick fed to the prescaler |
| evt_in | input | 1 | Asynchronous external event line |
| cap_lo_stb | input | 1 | Low-half capture strobe |
| cap_hi_stb | input | 1 | High-half capture strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Addressed register contents |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or 16-bit match flag |

## Verification
Count steps, capture loads, mode-write clears and match flags all take effect at the clock edge where their cause is present. The bench therefore drives stimulus on the falling edge, advances its own model at the next rising edge, and compares `irq_lo`, `irq_hi` and `rd_data` at the falling edge that follows. Because reads are combinational, the value read reflects the state one edge after the stimulus. An event level is due two edges after it is first driven, and the model holds a matching three-stage pipe so that event counts line up to the cycle. The directed prescaler and event cases state their expected counts as fixed numbers, taken only after the required number of edges has passed.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int CT_HALF_W = 8;
    localparam int CT_FULL_W = 2 * CT_HALF_W;
    localparam int CT_PSC_W  = 8;
    localparam int CT_ADDR_W = 3;
    localparam int CT_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_DUAL8    = 2'd0,
        MODE_MIXED    = 2'd1,
        MODE_WIDE_TMR = 2'd2,
        MODE_WIDE_EVT = 2'd3
    } ct_mode_e;

    typedef enum logic [CT_ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_PSC  = 3'd1,
        A_MLO  = 3'd2,
        A_MHI  = 3'd3,
        A_CLO  = 3'd4,
        A_CHI  = 3'd5,
        A_NLO  = 3'd6,
        A_NHI  = 3'd7
    } ct_addr_e;

    typedef struct packed {
        logic [CT_HALF_W-1:0] hi;
        logic [CT_HALF_W-1:0] lo;
    } ct_pair_t;

    function automatic logic is_wide(input ct_mode_e m);
        return m[1];
    endfunction

    function automatic logic lo_from_evt(input ct_mode_e m);
        return m == MODE_WIDE_EVT;
    endfunction

    function automatic logic hi_from_evt(input ct_mode_e m);
        return m == MODE_MIXED;
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import ct_pkg::*;
#(
    parameter int W = CT_PSC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         pulse
);

    logic [W-1:0] phase_q;

    assign pulse = tick && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (tick) begin
            if (phase_q == limit) phase_q <= '0;
            else                  phase_q <= phase_q + W'(1);
        end
    end

    AST_PSC_GATED: assert property (@(posedge clk) disable iff (rst)
        pulse |-> tick); // R1

    AST_PSC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && phase_q != limit) |=> phase_q == $past(phase_q) + W'(1)); // R1

endmodule

// File: rtl/ct_edge_sync.sv
module ct_edge_sync
    import ct_pkg::*;
#(
    parameter int STAGES = CT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    assign rise = pipe_q[STAGES-1] && !pipe_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R3

endmodule

// File: rtl/ct_count_pair.sv
module ct_count_pair
    import ct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     wide,
    input  logic     en_lo,
    input  logic     en_hi,
    input  ct_pair_t match,
    output ct_pair_t cnt,
    output logic     hit_lo,
    output logic     hit_hi
);

    localparam int HW = CT_HALF_W;
    localparam int FW = CT_FULL_W;

    logic [FW-1:0] cnt_q;
    logic [HW-1:0] lo_q, hi_q;

    assign lo_q = cnt_q[HW-1:0];
    assign hi_q = cnt_q[FW-1:HW];
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            hit_lo <= 1'b0;
            hit_hi <= 1'b0;
        end else begin
            hit_lo <= 1'b0;
            hit_hi <= 1'b0;
            if (wide) begin
                if (en_lo) begin
                    if (cnt_q == match) begin
                        cnt_q  <= '0;
                        hit_hi <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + FW'(1);
                    end
                end
            end else begin
                if (en_lo) begin
                    if (lo_q == match.lo) begin
                        cnt_q[HW-1:0] <= '0;
                        hit_lo        <= 1'b1;
                    end else begin
                        cnt_q[HW-1:0] <= lo_q + HW'(1);
                    end
                end
                if (en_hi) begin
                    if (hi_q == match.hi) begin
                        cnt_q[FW-1:HW] <= '0;
                        hit_hi         <= 1'b1;
                    end else begin
                        cnt_q[FW-1:HW] <= hi_q + HW'(1);
                    end
                end
            end
        end
    end

    AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && wide && en_lo && cnt == match) |=> (cnt == '0 && hit_hi)); // R6

    AST_WIDE_NO_LO: assert property (@(posedge clk) disable iff (rst)
        (wide && !clr) |=> !hit_lo); // R4

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wide && !en_lo) |=> $stable(cnt.lo)); // R2

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import ct_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 evt_in,
    input  logic                 cap_lo_stb,
    input  logic                 cap_hi_stb,
    input  logic                 wr_en,
    input  logic [CT_ADDR_W-1:0] wr_addr,
    input  logic [CT_HALF_W-1:0] wr_data,
    input  logic [CT_ADDR_W-1:0] rd_addr,
    output logic [CT_HALF_W-1:0] rd_data,
    output logic                 irq_lo,
    output logic                 irq_hi
);

    ct_mode_e             mode_q;
    logic [CT_PSC_W-1:0]  psc_q;
    ct_pair_t             match_q;
    ct_pair_t             cap_q;
    ct_pair_t             cnt;
    logic                 pre_en, evt_rise, wide, en_lo, en_hi, mode_wr;

    assign mode_wr = wr_en && (ct_addr_e'(wr_addr) == A_MODE);
    assign wide    = is_wide(mode_q);
    assign en_lo   = lo_from_evt(mode_q) ? evt_rise : pre_en;
    assign en_hi   = hi_from_evt(mode_q) ? evt_rise : pre_en;

    ct_prescaler #(.W(CT_PSC_W)) u_psc (
        .clk   (clk),
        .rst   (rst),
        .clr   (mode_wr),
        .tick  (tick),
        .limit (psc_q),
        .pulse (pre_en)
    );

    ct_edge_sync #(.STAGES(CT_SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .rise     (evt_rise)
    );

    ct_count_pair u_pair (
        .clk    (clk),
        .rst    (rst),
        .clr    (mode_wr),
        .wide   (wide),
        .en_lo  (en_lo),
        .en_hi  (en_hi),
        .match  (match_q),
        .cnt    (cnt),
        .hit_lo (irq_lo),
        .hit_hi (irq_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_DUAL8;
            psc_q   <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            case (ct_addr_e'(wr_addr))
                A_MODE:  mode_q     <= ct_mode_e'(wr_data[1:0]);
                A_PSC:   psc_q      <= wr_data;
                A_MLO:   match_q.lo <= wr_data;
                A_MHI:   match_q.hi <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (wide) begin
            if (cap_lo_stb || cap_hi_stb) cap_q <= cnt;
        end else begin
            if (cap_lo_stb) cap_q.lo <= cnt.lo;
            if (cap_hi_stb) cap_q.hi <= cnt.hi;
        end
    end

    always_comb begin
        case (ct_addr_e'(rd_addr))
            A_MODE:  rd_data = {{(CT_HALF_W-2){1'b0}}, mode_q};
            A_PSC:   rd_data = psc_q;
            A_MLO:   rd_data = match_q.lo;
            A_MHI:   rd_data = match_q.hi;
            A_CLO:   rd_data = cap_q.lo;
            A_CHI:   rd_data = cap_q.hi;
            A_NLO:   rd_data = cnt.lo;
            default: rd_data = cnt.hi;
        endcase
    end

    AST_MODE_CLR: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (cnt == '0 && !irq_lo && !irq_hi)); // R9

    AST_CAP_NARROW: assert property (@(posedge clk) disable iff (rst)
        (cap_lo_stb && !wide) |=> cap_q.lo == $past(cnt.lo)); // R7

    AST_CAP_WIDE: assert property (@(posedge clk) disable iff (rst)
        ((cap_lo_stb || cap_hi_stb) && wide) |=> cap_q == $past(cnt)); // R8

endmodule

// File: tb/cap_timer_tb.sv
module cap_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick, evt_in, cap_lo_stb, cap_hi_stb, wr_en;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       irq_lo, irq_hi;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference model state
    logic [1:0] m_mode;
    logic [7:0] m_psc, m_mlo, m_mhi, m_clo, m_chi, m_lo, m_hi, m_pcnt;
    logic       m_flo, m_fhi, m_s1, m_s2, m_s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .evt_in     (evt_in),
        .cap_lo_stb (cap_lo_stb),
        .cap_hi_stb (cap_hi_stb),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_lo     (irq_lo),
        .irq_hi     (irq_hi)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {6'd0, m_mode};
            3'd1: return m_psc;
            3'd2: return m_mlo;
            3'd3: return m_mhi;
            3'd4: return m_clo;
            3'd5: return m_chi;
            3'd6: return m_lo;
            default: return m_hi;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        if (a <= 3'd3) return "R10";
        if (a <= 3'd5) return m_mode[1] ? "R8" : "R7";
        case (m_mode)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_psc = 0; m_mlo = 0; m_mhi = 0; m_clo = 0; m_chi = 0;
        m_lo = 0; m_hi = 0; m_pcnt = 0; m_flo = 0; m_fhi = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0;
    endtask

    // one rising edge of the reference, from the requirements
    task automatic model_step(input logic t, input logic e, input logic cl, input logic ch,
                              input logic we, input logic [2:0] wa, input logic [7:0] wd);
        logic pre, rise, enl, enh, wide;
        logic [15:0] c16;
        pre  = t && (m_pcnt == m_psc);
        rise = m_s2 && !m_s3;
        wide = m_mode[1];
        enl  = (m_mode == 2'd3) ? rise : pre;
        enh  = (m_mode == 2'd1) ? rise : pre;
        if (wide) begin
            if (cl || ch) begin m_clo = m_lo; m_chi = m_hi; end
        end else begin
            if (cl) m_clo = m_lo;
            if (ch) m_chi = m_hi;
        end
        m_flo = 0; m_fhi = 0;
        if (we && wa == 3'd0) begin
            m_lo = 0; m_hi = 0; m_pcnt = 0;
        end else begin
            if (t) m_pcnt = (m_pcnt == m_psc) ? 8'd0 : m_pcnt + 8'd1;
            if (wide) begin
                c16 = {m_hi, m_lo};
                if (enl) begin
                    if (c16 == {m_mhi, m_mlo}) begin c16 = 0; m_fhi = 1; end
                    else c16 = c16 + 16'd1;
                end
                {m_hi, m_lo} = c16;
            end else begin
                if (enl) begin
                    if (m_lo == m_mlo) begin m_lo = 0; m_flo = 1; end
                    else m_lo = m_lo + 8'd1;
                end
                if (enh) begin
                    if (m_hi == m_mhi) begin m_hi = 0; m_fhi = 1; end
                    else m_hi = m_hi + 8'd1;
                end
            end
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = e;
        if (we) begin
            case (wa)
                3'd0: m_mode = wd[1:0];
                3'd1: m_psc  = wd;
                3'd2: m_mlo  = wd;
                3'd3: m_mhi  = wd;
                default: ;
            endcase
        end
    endtask

    // called at a falling edge; ends at the next falling edge after comparing
    task automatic cycle(input logic t, input logic e, input logic cl, input logic ch,
                         input logic we, input logic [2:0] wa, input logic [7:0] wd,
                         input logic [2:0] ra);
        tick = t; evt_in = e; cap_lo_stb = cl; cap_hi_stb = ch;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        model_step(t, e, cl, ch, we, wa, wd);
        @(negedge clk);
        check("R6 irq_lo", {15'd0, irq_lo}, {15'd0, m_flo});
        check("R6 irq_hi", {15'd0, irq_hi}, {15'd0, m_fhi});
        check(read_tag(ra), {8'd0, rd_data}, {8'd0, model_read(ra)});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cycle(1'b0, evt_in, 1'b0, 1'b0, 1'b1, a, d, 3'd6);
    endtask

    task automatic read_now(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd2024));
        rst = 1'b1; tick = 0; evt_in = 0; cap_lo_stb = 0; cap_hi_stb = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        for (int a = 0; a < 8; a++) begin
            read_now(3'(a), v);
            check("R11 reset read", {8'd0, v}, 16'd0);
        end
        check("R11 irq_lo", {15'd0, irq_lo}, 16'd0);
        check("R11 irq_hi", {15'd0, irq_hi}, 16'd0);

        // R10: register readback
        wr(3'd1, 8'hA5);
        read_now(3'd1, v);
        check("R10 prescale readback", {8'd0, v}, 16'h00A5);

        // R1: prescale 2 divides by 3; 9 ticks give 3 steps
        wr(3'd1, 8'd2); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'd0);
        for (int i = 0; i < 9; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 3'd6);
        read_now(3'd6, v);
        check("R1 low count after 9 ticks at prescale 2", {8'd0, v}, 16'd3);

        // R3: five event pulses counted in the high half of mode 1
        wr(3'd0, 8'd1);
        for (int i = 0; i < 5; i++) begin
            cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 3'd7);
            cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 3'd7);
            cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 3'd7);
            cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, 3'd7);
        end
        read_now(3'd7, v);
        check("R3 event count", {8'd0, v}, 16'd5);

        // R9: mode write clears the counters
        wr(3'd0, 8'd1);
        read_now(3'd7, v);
        check("R9 high count after mode write", {8'd0, v}, 16'd0);
        read_now(3'd6, v);
        check("R9 low count after mode write", {8'd0, v}, 16'd0);

        // random phases, one per mode (R2, R3, R4, R5, R6, R7, R8)
        for (int m = 0; m < 4; m++) begin
            wr(3'd1, 8'($urandom_range(0, 3)));
            wr(3'd2, 8'($urandom_range(0, 9)));
            wr(3'd3, (m >= 2) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 9)));
            wr(3'd0, 8'(m));
            for (int i = 0; i < 3000; i++) begin
                logic we;
                logic [2:0] wa;
                logic [7:0] wd;
                we = ($urandom_range(0, 79) == 0);
                wa = 3'($urandom_range(0, 3));
                case (wa)
                    3'd0: wd = 8'(m);
                    3'd1: wd = 8'($urandom_range(0, 3));
                    3'd2: wd = 8'($urandom_range(0, 9));
                    default: wd = (m >= 2) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 9));
                endcase
                cycle(($urandom_range(0, 3) != 0),
                      ($urandom_range(0, 2) == 0) ? ~evt_in : evt_in,
                      ($urandom_range(0, 15) == 0),
                      ($urandom_range(0, 15) == 0),
                      we, wa, wd, 3'($urandom_range(0, 7)));
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule